// File: doc/BRIEF.md
# Video Memory Address Decoder with Nametable Mirroring

This block sits on the 14-bit video-side address bus of a tile-based graphics controller and splits that space into three regions. The lower half goes to an external 8 KB pattern memory, with the local address and strobes forwarded on a dedicated port. Most of the upper half goes to a 2 KB nametable RAM inside the block. The final 256-byte page goes to a 32-entry palette RAM that is also inside the block.

Each region has its own active-low select. Exactly one select is low for any address. The nametable window holds four 1 KB quarters, and only two of them can be distinct. A mirroring mode input chooses whether the quarters pair up side by side or one above the other. The 0x3000 block repeats the nametable window. The palette repeats every 32 bytes, and four of its background-colour entries share storage with their sprite-side counterparts.

Reads and writes use one clock and a pair of strobes. Read data from the internal RAMs is registered and appears in the cycle after the read strobe. A pattern read presents whatever the external memory returns in that same following cycle.

Top module: `vmd_addr_decoder`

## Requirements
- R1: For addresses 0x0000–0x1FFF, `pat_cs_n` is low and `pat_addr` equals address bits 12..0. `pat_rd_en` follows `rd_en` and `pat_wr_en` follows `wr_en`. `pat_wr_data` carries `wr_data`.
- R2: For every address, exactly one of `pat_cs_n`, `nt_cs_n` and `pal_cs_n` is low. Address bit 13 = 0 selects the pattern region. Bit 13 = 1 selects either the nametable or the palette.
- R3: With `mirror_horiz` = 0, `nt_addr` is {address bit 10, address bits 9..0}. Quarters 0x2000 and 0x2800 share storage, and quarters 0x2400 and 0x2C00 share storage.
- R4: With `mirror_horiz` = 1, `nt_addr` is {address bit 11, address bits 9..0}. Quarters 0x2000 and 0x2400 share storage, and quarters 0x2800 and 0x2C00 share storage.
- R5: An address in 0x3000–0x3EFF reaches the same nametable location as the address 0x1000 below it.
- R6: Addresses 0x3F00–0x3FFF assert `pal_cs_n` low and keep `nt_cs_n` high. A write in this page changes no nametable location.
- R7: `pal_addr` is address bits 4..0, except that indices 0x10, 0x14, 0x18 and 0x1C become 0x00, 0x04, 0x08 and 0x0C. This holds for both reads and writes.
- R8: A read strobed in one cycle returns its data on `rd_data` in the next cycle. For internal RAMs this is the stored byte. For the pattern region it is the value on `pat_rd_data` during that next cycle.
- R9: While `rst` is high, and after it falls until the first read, `rd_data` is zero.
- R10: A byte written with `wr_en` to a nametable or palette address is returned by any later read of an address that aliases the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mirror_horiz | input | 1 | Mirroring mode: 0 vertical, 1 horizontal |
| bus_addr | input | 14 | Video bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the read strobe |
| pat_cs_n | output | 1 | Pattern memory select, active low |
| pat_addr | output | 13 | Pattern memory local address |
| pat_rd_en | output | 1 | Pattern read strobe |
| pat_wr_en | output | 1 | Pattern write strobe |
| pat_wr_data | output | 8 | Pattern write data |
| pat_rd_data | input | 8 | Data returned by the pattern memory |
| nt_cs_n | output | 1 | Nametable RAM select, active low |
| nt_addr | output | 11 | Translated nametable RAM address |
| pal_cs_n | output | 1 | Palette RAM select, active low |
| pal_addr | output | 5 | Translated palette index after aliasing |

## Verification
The bench builds the block with its default parameters: a 14-bit bus, an 11-bit nametable address and a 5-bit palette index. At these sizes all 16,384 addresses can be swept in both mirroring modes, so every select and translated address is compared exhaustively. The whole nametable is filled through one alias and then read back through every other alias in each mode. The palette page is read back in full after its aliased entries have been overwritten.

// File: rtl/vmd_pkg.sv
package vmd_pkg;
  typedef enum logic [1:0] {
    REG_PAT = 2'd0,
    REG_NT  = 2'd1,
    REG_PAL = 2'd2
  } vmd_region_e;
endpackage

// File: rtl/vmd_spram.sv
module vmd_spram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[addr];
  end

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(q));
endmodule

// File: rtl/vmd_region_decode.sv
module vmd_region_decode
  import vmd_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int PAGE_LSB = 8
) (
  input  logic [ADDR_W-1:PAGE_LSB] page,
  output vmd_region_e              region,
  output logic                     pat_cs_n,
  output logic                     nt_cs_n,
  output logic                     pal_cs_n
);
  logic upper, pal_page;

  always_comb begin
    upper    = page[ADDR_W-1];
    pal_page = &page;
    pat_cs_n = upper;
    pal_cs_n = ~pal_page;
    nt_cs_n  = ~(upper & ~pal_page);
    if (!upper)        region = REG_PAT;
    else if (pal_page) region = REG_PAL;
    else               region = REG_NT;
  end
endmodule

// File: rtl/vmd_nt_fold.sv
module vmd_nt_fold #(
  parameter int NT_AW = 11
) (
  input  logic             horiz,
  input  logic [NT_AW:0]   a,
  output logic [NT_AW-1:0] nt_addr
);
  localparam int QW = NT_AW - 1;

  always_comb begin
    nt_addr = {(horiz ? a[QW+1] : a[QW]), a[QW-1:0]};
  end
endmodule

// File: rtl/vmd_palette.sv
module vmd_palette #(
  parameter int PAL_AW = 5,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [PAL_AW-1:0] idx,
  input  logic [DW-1:0]     wdata,
  output logic [PAL_AW-1:0] ram_idx,
  output logic [DW-1:0]     q
);
  logic shared;

  always_comb begin
    shared  = idx[PAL_AW-1] & (idx[1:0] == 2'b00);
    ram_idx = idx;
    if (shared) ram_idx[PAL_AW-1] = 1'b0;
  end

  always_comb begin
    // R7
    pal_fold_chk: assert (!(ram_idx[PAL_AW-1] && ram_idx[1:0] == 2'b00));
  end

  vmd_spram #(.AW(PAL_AW), .DW(DW)) pal_mem_i (
    .clk(clk), .rst(rst), .we(we), .re(re),
    .addr(ram_idx), .wdata(wdata), .q(q)
  );
endmodule

// File: rtl/vmd_addr_decoder.sv
module vmd_addr_decoder
  import vmd_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int NT_AW    = 11,
  parameter int PAL_AW   = 5,
  parameter int PAGE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mirror_horiz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pat_cs_n,
  output logic [ADDR_W-2:0] pat_addr,
  output logic              pat_rd_en,
  output logic              pat_wr_en,
  output logic [DATA_W-1:0] pat_wr_data,
  input  logic [DATA_W-1:0] pat_rd_data,
  output logic              nt_cs_n,
  output logic [NT_AW-1:0]  nt_addr,
  output logic              pal_cs_n,
  output logic [PAL_AW-1:0] pal_addr
);
  localparam int PAT_AW = ADDR_W - 1;

  vmd_region_e         region, region_q;
  logic                nt_we, nt_re, pal_we, pal_re;
  logic [DATA_W-1:0]   nt_q, pal_q;

  vmd_region_decode #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) dec_i (
    .page(bus_addr[ADDR_W-1:PAGE_LSB]), .region(region),
    .pat_cs_n(pat_cs_n), .nt_cs_n(nt_cs_n), .pal_cs_n(pal_cs_n)
  );

  vmd_nt_fold #(.NT_AW(NT_AW)) fold_i (
    .horiz(mirror_horiz), .a(bus_addr[NT_AW:0]), .nt_addr(nt_addr)
  );

  assign pat_addr    = bus_addr[PAT_AW-1:0];
  assign pat_rd_en   = rd_en & ~pat_cs_n;
  assign pat_wr_en   = wr_en & ~pat_cs_n;
  assign pat_wr_data = wr_data;

  assign nt_we  = wr_en & ~nt_cs_n;
  assign nt_re  = rd_en & ~nt_cs_n;
  assign pal_we = wr_en & ~pal_cs_n;
  assign pal_re = rd_en & ~pal_cs_n;

  vmd_spram #(.AW(NT_AW), .DW(DATA_W)) nt_mem_i (
    .clk(clk), .rst(rst), .we(nt_we), .re(nt_re),
    .addr(nt_addr), .wdata(wr_data), .q(nt_q)
  );

  vmd_palette #(.PAL_AW(PAL_AW), .DW(DATA_W)) pal_i (
    .clk(clk), .rst(rst), .we(pal_we), .re(pal_re),
    .idx(bus_addr[PAL_AW-1:0]), .wdata(wr_data),
    .ram_idx(pal_addr), .q(pal_q)
  );

  always_ff @(posedge clk) begin
    if (rst)        region_q <= REG_NT;
    else if (rd_en) region_q <= region;
  end

  always_comb begin
    case (region_q)
      REG_PAT: rd_data = pat_rd_data;
      REG_PAL: rd_data = pal_q;
      default: rd_data = nt_q;
    endcase
  end

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~pat_cs_n, ~nt_cs_n, ~pal_cs_n}) == 1);

  // R1
  pat_map_chk: assert property (@(posedge clk) disable iff (rst)
    !pat_cs_n |-> (bus_addr[ADDR_W-1] == 1'b0));

  // R6
  nt_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !pal_cs_n |-> (!nt_we && !nt_re));

  // R8
  pat_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !pat_cs_n) |=> (rd_data == pat_rd_data));
endmodule

// File: tb/vmd_addr_decoder_tb.sv
module vmd_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mirror_horiz = 1'b0;
  logic [13:0] bus_addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        pat_cs_n, pat_rd_en, pat_wr_en, nt_cs_n, pal_cs_n;
  logic [12:0] pat_addr;
  logic [7:0]  pat_wr_data;
  logic [7:0]  pat_rd_data = '0;
  logic [10:0] nt_addr;
  logic [4:0]  pal_addr;

  int compared = 0, mismatched = 0;
  int nt_model [2048];
  int pal_model [32];

  always #4 clk = ~clk;

  vmd_addr_decoder dut_i (
    .clk(clk), .rst(rst), .mirror_horiz(mirror_horiz), .bus_addr(bus_addr),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pat_cs_n(pat_cs_n), .pat_addr(pat_addr), .pat_rd_en(pat_rd_en),
    .pat_wr_en(pat_wr_en), .pat_wr_data(pat_wr_data), .pat_rd_data(pat_rd_data),
    .nt_cs_n(nt_cs_n), .nt_addr(nt_addr), .pal_cs_n(pal_cs_n), .pal_addr(pal_addr)
  );

  function automatic int pat_fn(int a);
    return (a * 7 + (a >> 8) + 3) & 255;
  endfunction

  // external pattern memory: synchronous, answers the cycle after a read
  always @(posedge clk)
    if (!pat_cs_n && pat_rd_en) pat_rd_data <= 8'(pat_fn(int'(pat_addr)));

  function automatic int nt_idx(int a, bit h);
    int quarter = (a >> 10) & 3;
    int half = h ? (quarter / 2) : (quarter % 2);
    return half * 1024 + (a % 1024);
  endfunction

  function automatic int pal_idx(int a);
    int i = a % 32;
    if (i >= 16 && (i % 4) == 0) i = i - 16;
    return i;
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h mode %0d)",
               req, act, exp, bus_addr, mirror_horiz);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 14'(a); wr_data = 8'(d); wr_en = 1'b1;
    if (a < 'h2000) nt_model[0] = nt_model[0];
    else if (a >= 'h3F00) pal_model[pal_idx(a)] = d & 255;
    else nt_model[nt_idx(a, mirror_horiz)] = d & 255;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk);
    bus_addr = 14'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1 chk(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 chk("R9 reset", int'(rd_data), 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk("R9 after reset", int'(rd_data), 0);

    // exhaustive address sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16384; a++) begin
        @(negedge clk);
        mirror_horiz = m[0]; bus_addr = 14'(a);
        #1;
        if (a < 'h2000) begin
          chk("R1/R2 pattern selects", {pat_cs_n, nt_cs_n, pal_cs_n}, 3'b011);
          chk("R1 pattern address", int'(pat_addr), a);
        end else if (a >= 'h3F00) begin
          chk("R2/R6 palette selects", {pat_cs_n, nt_cs_n, pal_cs_n}, 3'b110);
          chk("R7 palette index", int'(pal_addr), pal_idx(a));
        end else begin
          chk("R2 nametable selects", {pat_cs_n, nt_cs_n, pal_cs_n}, 3'b101);
          chk(m ? "R4/R5 nt address" : "R3/R5 nt address",
              int'(nt_addr), nt_idx(a, m[0]));
        end
      end
    end

    // R3: vertical mode, fill through 0x2000..0x27FF, read all aliases
    @(negedge clk); mirror_horiz = 1'b0;
    for (int i = 0; i < 2048; i++) wr('h2000 + i, i * 3 + 1);
    for (int a = 'h2000; a < 'h3F00; a++)
      rd(a, nt_model[nt_idx(a, 1'b0)], "R3/R5/R8/R10 vertical read");

    // R4: horizontal mode, fill through the 0x3000 alias block
    @(negedge clk); mirror_horiz = 1'b1;
    for (int i = 0; i < 1024; i++) wr('h3000 + i, i * 5 + 7);
    for (int i = 0; i < 1024; i++) wr('h3800 + i, i * 11 + 2);
    for (int a = 'h2000; a < 'h3F00; a++)
      rd(a, nt_model[nt_idx(a, 1'b1)], "R4/R5/R8/R10 horizontal read");

    // R6/R7: palette fill, shared entries overwritten by their aliases
    for (int i = 0; i < 32; i++) wr('h3F00 + i, 'hC0 ^ (i * 9));
    wr('h3F24, 'h5A);
    wr('h3FF0, 'h3C);
    for (int a = 'h3F00; a < 'h4000; a++)
      rd(a, pal_model[pal_idx(a)], "R7/R8/R10 palette read");
    // R6: nametable storage behind the palette page left untouched
    for (int a = 'h2F00; a < 'h3000; a++)
      rd(a, nt_model[nt_idx(a, 1'b1)], "R6 nt untouched by palette writes");

    // R1: pattern write strobes at the port
    @(negedge clk);
    bus_addr = 14'h0123; wr_data = 8'h9E; wr_en = 1'b1;
    #1;
    chk("R1 pat_wr_en", int'(pat_wr_en), 1);
    chk("R1 pat_wr_data", int'(pat_wr_data), 'h9E);
    chk("R1 pat_rd_en idle", int'(pat_rd_en), 0);
    @(negedge clk); wr_en = 1'b0;
    #1 chk("R1 pat_wr_en released", int'(pat_wr_en), 0);

    // R8: pattern reads pass external data through
    for (int a = 0; a < 256; a++) rd(a, pat_fn(a), "R1/R8 pattern read low");
    for (int a = 'h1F00; a < 'h2000; a++) rd(a, pat_fn(a), "R1/R8 pattern read high");

    // R10: internal data still reachable after pattern traffic
    rd('h2C05, nt_model[nt_idx('h2C05, 1'b1)], "R10 nt after pattern reads");
    rd('h3F10, pal_model[0], "R7 shared entry after pattern reads");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule